// File: doc/BRIEF.md
# Bisync Transmit Framer with Transparent DLE Stuffing

This block turns a byte stream into a character-synchronous serial line. Each character goes out over eight transmit clock enables, least significant bit first. Whenever no block is in progress, the line carries SYNC characters. Bytes arrive on a valid/ready interface, and three sideband flags travel with each byte:
- a flag that lets the byte take part in the block check;
- a flag that clears the block check generator before the byte is counted;
- a flag that marks the byte as the final one of the block.

A buffer that must stay out of the check is presented as its own run of bytes with the include flag low.

The block runs in one of two modes:
- In normal mode, every byte is sent as given. If the source runs dry in the middle of a block, SYNC characters fill the line.
- In transparent mode, a data byte equal to DLE is sent twice, but only one copy enters the check. A mid-block underrun is filled with DLE followed by SYNC.

After the final byte of a block, the 16-bit check goes out low byte first. At least one SYNC follows it before another block can start.

Top module: `bsc_tx_framer`

## Requirements
- R1: After reset, the line sends SYNC (0x32) characters back to back whenever no block is in progress, including in transparent mode. Character boundaries fall every eight transmit enables, counted from reset.
- R2: Each character is sent least significant bit first. One bit is sent per cycle with `bit_en` high, and `tx_bit` does not change after a cycle in which `bit_en` was low.
- R3: `in_ready` is high only in a cycle with `bit_en` high that ends a character. Each accepted byte is sent once, in the order it was accepted.
- R4: In normal mode, if no byte is valid at a character boundary inside a block, a SYNC (0x32) is sent in its place. The block then continues with the next byte.
- R5: In transparent mode, a mid-block underrun sends the pair DLE (0x10), SYNC (0x32), and never a lone SYNC.
- R6: In transparent mode, a data byte 0x10 is sent as 0x10 0x10. In normal mode it is sent once.
- R7: The block check is a CRC16 with polynomial x^16+x^15+x^2+1. It is computed bit-reflected (shift right, XOR 0xA001 when the bit shifted out is 1) over each included byte, and it starts from 0 after reset. Fill characters and the inserted DLE are never counted, so a doubled DLE counts once.
- R8: A byte with `in_bcs_en` low is sent but leaves the check unchanged.
- R9: A byte with `in_bcs_reset` high clears the check to 0 before that byte is counted. Without it, the check keeps accumulating across blocks.
- R10: The character after the final byte is the check's low byte, then comes its high byte, then at least one SYNC. This order holds even when the final byte is a doubled DLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Transmit clock enable, one bit per high cycle |
| transparent | input | 1 | 1 selects transparent mode; change it only between blocks |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| in_data | input | 8 | Input byte |
| in_bcs_en | input | 1 | Include this byte in the block check |
| in_bcs_reset | input | 1 | Clear the block check before this byte |
| in_last | input | 1 | Final byte of the block |
| tx_bit | output | 1 | Serial line output |

## Verification
The bench builds the framer with its default parameters: 8-bit characters, SYNC 0x32, DLE 0x10 and the reflected 0xA001 polynomial. With these values the two control characters can be placed in the data stream at will, so doubled DLEs, a DLE as the final byte and fill characters between data can all be checked against a reference CRC computed in the bench. The transmit enable runs both every cycle and every third cycle. With every-cycle enables, underruns are easy to provoke. With every-third-cycle enables, the bench can see whether the line holds still between bits.

// File: rtl/bsc_tx_pkg.sv
package bsc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_FRAME    = 3'd1,
    ST_DLE_DATA = 3'd2,
    ST_FILL_SYN = 3'd3,
    ST_CRC_LO   = 3'd4,
    ST_CRC_HI   = 3'd5,
    ST_TRAIL    = 3'd6
  } seq_state_t;

endpackage

// File: rtl/bsc_tx_serializer.sv
module bsc_tx_serializer #(
  parameter int unsigned          CHAR_W    = 8,
  parameter logic [CHAR_W-1:0]    IDLE_CHAR = 8'h32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [CHAR_W-1:0] load_char,
  output logic              load,
  output logic [CHAR_W-1:0] shreg,
  output logic              tx_bit
);

  localparam int unsigned        CNT_W    = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [CNT_W-1:0]   LAST_CNT = CNT_W'(CHAR_W - 1);

  logic [CHAR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign load = bit_en && (cnt_q == LAST_CNT);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (bit_en) begin
      if (cnt_q == LAST_CNT) begin
        sh_d  = load_char;
        cnt_d = '0;
      end else begin
        sh_d  = sh_q >> 1;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= IDLE_CHAR;
      cnt_q <= '0;
    end else if (bit_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign shreg  = sh_q;
  assign tx_bit = sh_q[0];

endmodule

// File: rtl/bsc_tx_crc.sv
module bsc_tx_crc #(
  parameter int unsigned         CHAR_W    = 8,
  parameter int unsigned         CRC_W     = 16,
  parameter logic [CRC_W-1:0]    POLY_REFL = 16'hA001,
  parameter logic [CRC_W-1:0]    INIT      = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [CHAR_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);

  logic [CRC_W-1:0] crc_q, crc_d, base, folded;

  assign base = clr ? INIT : crc_q;

  always_comb begin
    folded = base ^ CRC_W'(data);
    for (int b = 0; b < int'(CHAR_W); b++) begin
      if (folded[0]) folded = (folded >> 1) ^ POLY_REFL;
      else           folded = folded >> 1;
    end
  end

  always_comb begin
    crc_d = upd ? folded : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= INIT;
    else if (clr || upd) crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/bsc_tx_sequencer.sv
module bsc_tx_sequencer
  import bsc_tx_pkg::*;
#(
  parameter int unsigned       CHAR_W    = 8,
  parameter logic [CHAR_W-1:0] SYNC_CHAR = 8'h32,
  parameter logic [CHAR_W-1:0] DLE_CHAR  = 8'h10,
  localparam int unsigned      CRC_W     = 2 * CHAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              transparent,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_bcs_en,
  input  logic              in_bcs_reset,
  input  logic              in_last,
  input  logic [CRC_W-1:0]  crc,
  output logic              crc_clr,
  output logic              crc_upd,
  output logic [CHAR_W-1:0] crc_byte,
  output logic [CHAR_W-1:0] next_char,
  output seq_state_t        state
);

  seq_state_t state_q, state_d;
  logic       pend_en_q, pend_en_d;
  logic       pend_last_q, pend_last_d;
  logic       open_slot;

  assign open_slot = (state_q == ST_IDLE) || (state_q == ST_FRAME);
  assign in_ready  = load && open_slot;

  always_comb begin
    state_d     = state_q;
    pend_en_d   = pend_en_q;
    pend_last_d = pend_last_q;
    next_char   = SYNC_CHAR;
    crc_clr     = 1'b0;
    crc_upd     = 1'b0;
    crc_byte    = in_data;
    if (load) begin
      unique case (state_q)
        ST_IDLE, ST_FRAME: begin
          if (in_valid) begin
            crc_clr = in_bcs_reset;
            if (transparent && (in_data == DLE_CHAR)) begin
              next_char   = DLE_CHAR;
              pend_en_d   = in_bcs_en;
              pend_last_d = in_last;
              state_d     = ST_DLE_DATA;
            end else begin
              next_char = in_data;
              crc_upd   = in_bcs_en;
              state_d   = in_last ? ST_CRC_LO : ST_FRAME;
            end
          end else if ((state_q == ST_FRAME) && transparent) begin
            next_char = DLE_CHAR;
            state_d   = ST_FILL_SYN;
          end else begin
            next_char = SYNC_CHAR;
          end
        end
        ST_DLE_DATA: begin
          next_char = DLE_CHAR;
          crc_byte  = DLE_CHAR;
          crc_upd   = pend_en_q;
          state_d   = pend_last_q ? ST_CRC_LO : ST_FRAME;
        end
        ST_FILL_SYN: begin
          next_char = SYNC_CHAR;
          state_d   = ST_FRAME;
        end
        ST_CRC_LO: begin
          next_char = crc[CHAR_W-1:0];
          state_d   = ST_CRC_HI;
        end
        ST_CRC_HI: begin
          next_char = crc[CRC_W-1:CHAR_W];
          state_d   = ST_TRAIL;
        end
        ST_TRAIL: begin
          next_char = SYNC_CHAR;
          state_d   = ST_IDLE;
        end
        default: begin
          next_char = SYNC_CHAR;
          state_d   = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_en_q   <= 1'b0;
      pend_last_q <= 1'b0;
    end else if (load) begin
      state_q     <= state_d;
      pend_en_q   <= pend_en_d;
      pend_last_q <= pend_last_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/bsc_tx_framer.sv
module bsc_tx_framer
  import bsc_tx_pkg::*;
#(
  parameter int unsigned       CHAR_W    = 8,
  parameter logic [CHAR_W-1:0] SYNC_CHAR = 8'h32,
  parameter logic [CHAR_W-1:0] DLE_CHAR  = 8'h10,
  parameter logic [2*CHAR_W-1:0] CRC_POLY_REFL = 16'hA001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              transparent,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_bcs_en,
  input  logic              in_bcs_reset,
  input  logic              in_last,
  output logic              tx_bit
);

  localparam int unsigned CRC_W = 2 * CHAR_W;

  logic              load;
  logic [CHAR_W-1:0] next_char;
  logic [CHAR_W-1:0] shreg;
  logic [CRC_W-1:0]  crc;
  logic              crc_clr, crc_upd;
  logic [CHAR_W-1:0] crc_byte;
  seq_state_t        seq_state;

  bsc_tx_serializer #(
    .CHAR_W    (CHAR_W),
    .IDLE_CHAR (SYNC_CHAR)
  ) ser_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .load_char (next_char),
    .load      (load),
    .shreg     (shreg),
    .tx_bit    (tx_bit)
  );

  bsc_tx_sequencer #(
    .CHAR_W    (CHAR_W),
    .SYNC_CHAR (SYNC_CHAR),
    .DLE_CHAR  (DLE_CHAR)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .transparent  (transparent),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .in_bcs_en    (in_bcs_en),
    .in_bcs_reset (in_bcs_reset),
    .in_last      (in_last),
    .crc          (crc),
    .crc_clr      (crc_clr),
    .crc_upd      (crc_upd),
    .crc_byte     (crc_byte),
    .next_char    (next_char),
    .state        (seq_state)
  );

  bsc_tx_crc #(
    .CHAR_W    (CHAR_W),
    .CRC_W     (CRC_W),
    .POLY_REFL (CRC_POLY_REFL),
    .INIT      ('0)
  ) crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .upd   (crc_upd),
    .data  (crc_byte),
    .crc   (crc)
  );

endmodule

// File: rtl/bsc_tx_checker.sv
module bsc_tx_checker
  import bsc_tx_pkg::*;
#(
  parameter int unsigned       CHAR_W    = 8,
  parameter logic [CHAR_W-1:0] SYNC_CHAR = 8'h32,
  parameter logic [CHAR_W-1:0] DLE_CHAR  = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              transparent,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CHAR_W-1:0] in_data,
  input logic              tx_bit,
  input logic              load,
  input logic [CHAR_W-1:0] shreg,
  input seq_state_t        seq_state
);

  // R2: line holds when no transmit enable
  a_r2_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  // R3: acceptance only on a character boundary
  a_r3_ready_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_en && load));

  // R4: normal-mode underrun sends SYNC
  a_r4_sync_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seq_state == ST_FRAME && !in_valid && !transparent)
      |=> (shreg == SYNC_CHAR && seq_state == ST_FRAME));

  // R5: transparent underrun starts a DLE-SYNC pair
  a_r5_dle_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seq_state == ST_FRAME && !in_valid && transparent)
      |=> (shreg == DLE_CHAR && seq_state == ST_FILL_SYN));

  // R6: DLE data byte starts with an inserted DLE
  a_r6_dle_insert: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && transparent && in_data == DLE_CHAR)
      |=> (shreg == DLE_CHAR && seq_state == ST_DLE_DATA && !in_ready));

  // R10: check low byte is followed by high byte
  a_r10_crc_order: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seq_state == ST_CRC_LO) |=> (seq_state == ST_CRC_HI));

endmodule

bind bsc_tx_framer bsc_tx_checker #(
  .CHAR_W    (CHAR_W),
  .SYNC_CHAR (SYNC_CHAR),
  .DLE_CHAR  (DLE_CHAR)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en      (bit_en),
  .transparent (transparent),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_data     (in_data),
  .tx_bit      (tx_bit),
  .load        (load),
  .shreg       (shreg),
  .seq_state   (seq_state)
);

// File: tb/bsc_tx_framer_tb_top.sv
module bsc_tx_framer_tb_top;

  localparam logic [7:0] SYN = 8'h32;
  localparam logic [7:0] DLE = 8'h10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       transparent = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_bcs_en = 1'b0;
  logic       in_bcs_reset = 1'b0;
  logic       in_last = 1'b0;
  logic       tx_bit;

  always #2 clk = ~clk;

  bsc_tx_framer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .transparent  (transparent),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .in_bcs_en    (in_bcs_en),
    .in_bcs_reset (in_bcs_reset),
    .in_last      (in_last),
    .tx_bit       (tx_bit)
  );

  int errors = 0;
  int checks = 0;

  // transmit enable generator
  int en_div = 1;
  int tick = 0;
  always @(posedge clk) begin
    tick   <= tick + 1;
    bit_en <= ((tick % en_div) == 0);
  end

  // line monitor
  logic [7:0] cap [0:4095];
  int         ncap = 0;
  logic [7:0] acc = 8'h00;
  int         nb = 0;
  logic       en_prev = 1'b0;
  logic       tx_prev = 1'b0;
  int         hold_viol = 0;
  int         ready_viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!en_prev && (tx_bit !== tx_prev)) hold_viol++;
      if (in_ready && !bit_en) ready_viol++;
      if (bit_en) begin
        acc = {tx_bit, acc[7:1]};
        nb++;
        if (nb == 8) begin
          if (ncap < 4096) cap[ncap] = acc;
          ncap++;
          nb = 0;
        end
      end
      en_prev = bit_en;
      tx_prev = tx_bit;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // reference model
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  logic [15:0] mcrc = 16'h0000;
  logic [7:0]  exp_c [0:63];
  int          nexp = 0;
  int          ndata = 0;
  int          fstart = 0;
  int          fills = 0;

  task automatic push(input logic [7:0] c);
    exp_c[nexp] = c;
    nexp++;
  endtask

  task automatic begin_frame();
    @(negedge clk);
    fstart = ncap;
    nexp   = 0;
    ndata  = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic en, input logic rs, input logic last);
    if (rs) mcrc = 16'h0000;
    if (transparent && d == DLE) begin push(DLE); push(DLE); end
    else push(d);
    if (en) mcrc = crc_step(mcrc, d);
    if (last) begin
      ndata = nexp;
      push(mcrc[7:0]);
      push(mcrc[15:8]);
    end
    in_valid = 1'b1; in_data = d; in_bcs_en = en; in_bcs_reset = rs; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic gap(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input int extra);
    int i;
    int bad;
    while (ncap < fstart + nexp + extra + 4) @(negedge clk);
    i = fstart; bad = 0; fills = 0;
    while (i < ncap && cap[i] == SYN) i++;
    for (int k = 0; k < nexp; k++) begin
      if (k > 0 && k < ndata) begin
        if (transparent) begin
          while (i + 1 < ncap && cap[i] == DLE && cap[i+1] == SYN) begin i += 2; fills++; end
        end else begin
          while (i < ncap && cap[i] == SYN) begin i++; fills++; end
        end
      end
      if (!bad && cap[i] !== exp_c[k]) begin
        bad = 1;
        errors++;
        $display("FAIL %s char %0d: got %0h expected %0h", req, k, cap[i], exp_c[k]);
      end
      i++;
    end
    checks++;
    chk("R10", "trailing SYNC", {24'h0, cap[i]}, {24'h0, SYN});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3", "in_ready in reset", {31'h0, in_ready}, 32'h0);
    chk("R1", "tx_bit in reset", {31'h0, tx_bit}, {31'h0, SYN[0]});
    @(posedge clk); #1 rst_n = 1'b1;
    while (ncap < 4) @(negedge clk);
    for (int k = 0; k < 4; k++) chk("R1", "idle char", {24'h0, cap[k]}, {24'h0, SYN});
  endtask

  task automatic t_normal_basic();  // R2 R6 R7 R10
    transparent = 1'b0;
    begin_frame();
    send(8'h41, 1, 1, 0); send(8'h42, 1, 0, 0); send(DLE, 1, 0, 0);
    send(8'h43, 1, 0, 0); send(8'h44, 1, 0, 1);
    check_frame("R6_R7_normal", 0);
  endtask

  task automatic t_exclude();       // R8
    begin_frame();
    send(8'h02, 0, 1, 0); send(8'h01, 0, 0, 0);
    send(8'h55, 1, 0, 0); send(8'h66, 1, 0, 1);
    check_frame("R8_exclude", 0);
  endtask

  task automatic t_accumulate();    // R9
    begin_frame();
    send(8'h71, 1, 0, 0); send(8'h72, 1, 0, 1);
    check_frame("R9_carry", 0);
    begin_frame();
    send(8'h11, 1, 0, 0); send(8'h22, 1, 1, 0); send(8'h33, 1, 0, 1);
    check_frame("R9_midreset", 0);
  endtask

  task automatic t_transparent();   // R6 R7 R10
    transparent = 1'b1;
    begin_frame();
    send(DLE, 1, 1, 0); send(8'h02, 1, 0, 0); send(DLE, 1, 0, 0);
    send(DLE, 1, 0, 0); send(8'h03, 1, 0, 1);
    check_frame("R6_R7_transparent", 0);
    begin_frame();
    send(8'h31, 1, 1, 0); send(DLE, 1, 0, 1);
    check_frame("R10_dle_last", 0);
  endtask

  task automatic t_underrun_normal(); // R4
    transparent = 1'b0;
    begin_frame();
    send(8'h41, 1, 1, 0); gap(40);
    send(8'h42, 1, 0, 0); gap(24);
    send(8'h43, 1, 0, 1);
    check_frame("R4_underrun", 12);
    chk("R4", "fill present", {31'h0, fills > 0}, 32'h1);
  endtask

  task automatic t_underrun_transp(); // R5
    transparent = 1'b1;
    begin_frame();
    send(8'h51, 1, 1, 0); gap(40);
    send(DLE, 1, 0, 0); gap(30);
    send(8'h53, 1, 0, 1);
    check_frame("R5_underrun", 16);
    chk("R5", "pair fill present", {31'h0, fills > 0}, 32'h1);
  endtask

  task automatic t_slow();          // R2
    transparent = 1'b0;
    en_div = 3;
    gap(60);
    begin_frame();
    send(8'h61, 1, 1, 0); send(8'h62, 1, 0, 0); send(8'h63, 0, 0, 1);
    check_frame("R2_slow", 0);
    en_div = 1;
    gap(60);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_normal_basic();
    t_exclude();
    t_accumulate();
    t_transparent();
    t_underrun_normal();
    t_underrun_transp();
    t_slow();
    chk("R2", "line changed without enable", hold_viol, 0);
    chk("R3", "ready without enable", ready_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule